// File: doc/BRIEF.md
# Increment-and-Skip Instruction Executor

This block executes two 8-bit register-file instructions of a small accumulator-style CPU. Both add one to a file register, modulo 256. One variant then skips the following instruction when the result is zero. The other skips it when the result is not zero. The executor takes a 16-bit instruction word from the issue logic and decodes it. It forms a 12-bit data-memory address from the 8-bit file field, a bank-select input and a per-instruction flag that chooses between the banked view and a fixed shared view. The incremented value goes either to the working register or back to the file register.

Each machine cycle lasts four clocks, one per phase: decode, read, process, write. When a skip is taken, the executor pulses a flush strobe to the fetch stage during the write phase. It then runs one empty machine cycle, or two when the fetch stage reports that the discarded instruction is two words long. It pulses a PC-advance strobe once for each discarded word. No condition flags exist in this block and none are produced.

Top module: `incskip_exec`

## Requirements
- R1: An instruction word is accepted only while `busy` is low and `instr_valid` is high, and only when bits [15:10] equal 001111 (skip when the result is zero) or 010010 (skip when the result is nonzero). Any other word is ignored: `busy` stays low and no memory access is made.
- R2: When bit 8 (the bank flag) is 0, the `bsr` input is ignored. A file field (bits [7:0]) below 0x80 addresses `{4'h0, f}`, and a file field of 0x80 or above addresses `{4'hF, f}`.
- R3: When bit 8 is 1, the address is `{bsr, f}`, using the `bsr` value present during the decode clock.
- R4: When bit 9 (the destination bit) is 1, the file register value plus one (mod 256) is written back to the same address with a single-clock `mem_we` pulse in the write phase, and `wreg` is unchanged.
- R5: When bit 9 is 0, the incremented value is loaded into `wreg`, visible from the write phase on, and no memory write occurs.
- R6: The zero variant takes the skip exactly when the 8-bit result is 0, and the nonzero variant exactly when it is not 0. A taken skip raises `skip_flush` for exactly one clock, in the write phase.
- R7: `busy` is high for 4 clocks without a skip, 8 clocks with a skip when `next_two_word` is 0, and 12 clocks when it is 1. `next_two_word` is sampled in the last clock of the write phase. `pc_adv` pulses once per discarded word, in the last phase of each empty cycle.
- R8: `q_phase` counts 0,1,2,3 through each machine cycle. `mem_re` is high for exactly one clock, in phase 1 (read), and the memory returns data one clock later.
- R9: `instr_valid` asserted while `busy` is high has no effect on memory, `wreg` or timing.
- R10: Synchronous reset drives `busy`, `wreg`, `mem_re`, `mem_we`, `skip_flush` and `pc_adv` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_valid | input | 1 | Instruction word offered |
| instr_word | input | 16 | Instruction word |
| bsr | input | 4 | Bank select value |
| next_two_word | input | 1 | Prefetched instruction is two words long |
| mem_rdata | input | 8 | Data memory read data, one clock after `mem_re` |
| busy | output | 1 | Instruction in progress, including empty cycles |
| q_phase | output | 2 | Current phase within the machine cycle |
| mem_addr | output | 12 | Data memory address |
| mem_re | output | 1 | Data memory read strobe |
| mem_we | output | 1 | Data memory write strobe |
| mem_wdata | output | 8 | Data memory write data |
| wreg | output | 8 | Working register |
| skip_flush | output | 1 | Discard the prefetched instruction |
| pc_adv | output | 1 | Advance the program counter by one word |

## Verification
A vector table runs both opcodes with every combination of destination bit and bank flag. The file values are chosen so that the increment does or does not wrap to zero: 0xFF wraps to 0x00, 0x7F goes to 0x80, and 0x00 goes to 0x01. Pairs of vectors with the same result but opposite opcode separate the two skip senses. File fields on both sides of 0x80, with the bank flag cleared and a nonzero `bsr`, show that the shared view ignores the bank input. Taken skips are paired with both values of `next_two_word` to separate the 8- and 12-clock lengths. Directed cases cover an unknown opcode and a second request made while busy.

// File: rtl/incskip_pkg.sv
package incskip_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_EXEC = 2'd1,
    SEQ_NOP  = 2'd2
  } seq_state_t;

  localparam int OPC_W = 6;
  localparam logic [OPC_W-1:0] OPC_INC_SKZ  = 6'b001111;
  localparam logic [OPC_W-1:0] OPC_INC_SKNZ = 6'b010010;

  // Phase numbering inside one machine cycle
  localparam logic [1:0] PH_DECODE  = 2'd0;
  localparam logic [1:0] PH_READ    = 2'd1;
  localparam logic [1:0] PH_PROCESS = 2'd2;
  localparam logic [1:0] PH_WRITE   = 2'd3;

  function automatic logic opc_known(input logic [OPC_W-1:0] opc);
    return (opc == OPC_INC_SKZ) || (opc == OPC_INC_SKNZ);
  endfunction

endpackage

// File: rtl/incskip_decode.sv
module incskip_decode
  import incskip_pkg::*;
#(
  parameter int IW = 16,
  parameter int FW = 8,
  parameter int BW = 4
) (
  input  logic [IW-1:0]    ir,
  input  logic [BW-1:0]    bank_sel,
  output logic             skip_on_nz,
  output logic             dst_file,
  output logic [BW+FW-1:0] addr
);
  localparam logic [BW-1:0] BANK_LO = '0;
  localparam logic [BW-1:0] BANK_HI = '1;

  logic [OPC_W-1:0] opc;
  logic [FW-1:0]    fld;
  logic             banked;

  assign opc        = ir[IW-1 -: OPC_W];
  assign fld        = ir[FW-1:0];
  assign banked     = ir[FW];
  assign dst_file   = ir[FW+1];
  assign skip_on_nz = (opc == OPC_INC_SKNZ);

  always_comb begin
    if (banked)
      addr = {bank_sel, fld};
    else if (fld[FW-1])
      addr = {BANK_HI, fld};
    else
      addr = {BANK_LO, fld};
  end
endmodule

// File: rtl/incskip_alu.sv
module incskip_alu #(
  parameter int DW = 8
) (
  input  logic [DW-1:0] opnd,
  input  logic          skip_on_nz,
  output logic [DW-1:0] result,
  output logic          take_skip
);
  logic is_zero;

  assign result    = opnd + DW'(1);
  assign is_zero   = (result == '0);
  assign take_skip = skip_on_nz ? !is_zero : is_zero;
endmodule

// File: rtl/incskip_seq.sv
module incskip_seq
  import incskip_pkg::*;
#(
  parameter int MAX_NOP = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic       skip_now,
  input  logic       two_word,
  output seq_state_t state,
  output logic [1:0] phase,
  output logic       busy
);
  localparam int CW = $clog2(MAX_NOP + 1);

  logic          skip_pend;
  logic [CW-1:0] nop_left;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= SEQ_IDLE;
      phase     <= PH_DECODE;
      busy      <= 1'b0;
      skip_pend <= 1'b0;
      nop_left  <= '0;
    end else begin
      case (state)
        SEQ_IDLE: begin
          phase <= PH_DECODE;
          if (start) begin
            state <= SEQ_EXEC;
            busy  <= 1'b1;
          end
        end
        SEQ_EXEC: begin
          phase <= phase + 2'd1;
          if (phase == PH_PROCESS)
            skip_pend <= skip_now;
          if (phase == PH_WRITE) begin
            if (skip_pend) begin
              state    <= SEQ_NOP;
              nop_left <= two_word ? CW'(2) : CW'(1);
            end else begin
              state <= SEQ_IDLE;
              busy  <= 1'b0;
            end
          end
        end
        SEQ_NOP: begin
          phase <= phase + 2'd1;
          if (phase == PH_WRITE) begin
            if (nop_left == CW'(1)) begin
              state <= SEQ_IDLE;
              busy  <= 1'b0;
            end else begin
              nop_left <= nop_left - CW'(1);
            end
          end
        end
        default: begin
          state <= SEQ_IDLE;
          busy  <= 1'b0;
        end
      endcase
    end
  end
endmodule

// File: rtl/incskip_exec.sv
module incskip_exec
  import incskip_pkg::*;
#(
  parameter int IW = 16,
  parameter int FW = 8,
  parameter int BW = 4,
  parameter int DW = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             instr_valid,
  input  logic [IW-1:0]    instr_word,
  input  logic [BW-1:0]    bsr,
  input  logic             next_two_word,
  input  logic [DW-1:0]    mem_rdata,
  output logic             busy,
  output logic [1:0]       q_phase,
  output logic [BW+FW-1:0] mem_addr,
  output logic             mem_re,
  output logic             mem_we,
  output logic [DW-1:0]    mem_wdata,
  output logic [DW-1:0]    wreg,
  output logic             skip_flush,
  output logic             pc_adv
);
  localparam int AW = BW + FW;

  seq_state_t     state;
  logic [IW-1:0]  ir;
  logic           start;
  logic           skip_on_nz;
  logic           dst_file;
  logic [AW-1:0]  dec_addr;
  logic [DW-1:0]  result;
  logic           take_skip;
  logic           in_exec;
  logic           in_nop;
  logic           at_read;
  logic           at_proc;

  assign start   = !busy && instr_valid && opc_known(instr_word[IW-1 -: OPC_W]);
  assign in_exec = (state == SEQ_EXEC);
  assign in_nop  = (state == SEQ_NOP);
  assign at_read = in_exec && (q_phase == PH_DECODE);
  assign at_proc = in_exec && (q_phase == PH_PROCESS);

  incskip_decode #(.IW(IW), .FW(FW), .BW(BW)) u_dec (
    .ir         (ir),
    .bank_sel   (bsr),
    .skip_on_nz (skip_on_nz),
    .dst_file   (dst_file),
    .addr       (dec_addr)
  );

  incskip_alu #(.DW(DW)) u_alu (
    .opnd       (mem_rdata),
    .skip_on_nz (skip_on_nz),
    .result     (result),
    .take_skip  (take_skip)
  );

  incskip_seq #(.MAX_NOP(2)) u_seq (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .skip_now (take_skip),
    .two_word (next_two_word),
    .state    (state),
    .phase    (q_phase),
    .busy     (busy)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ir         <= '0;
      mem_addr   <= '0;
      mem_re     <= 1'b0;
      mem_we     <= 1'b0;
      mem_wdata  <= '0;
      wreg       <= '0;
      skip_flush <= 1'b0;
      pc_adv     <= 1'b0;
    end else begin
      if (start)
        ir <= instr_word;
      mem_re <= at_read;
      if (at_read)
        mem_addr <= dec_addr;
      mem_we <= at_proc && dst_file;
      if (at_proc)
        mem_wdata <= result;
      if (at_proc && !dst_file)
        wreg <= result;
      skip_flush <= at_proc && take_skip;
      pc_adv     <= in_nop && (q_phase == PH_PROCESS);
    end
  end
endmodule

// File: rtl/incskip_exec_chk.sv
module incskip_exec_chk #(
  parameter int AW = 12,
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          busy,
  input logic [1:0]    q_phase,
  input logic [AW-1:0] mem_addr,
  input logic          mem_re,
  input logic          mem_we,
  input logic [DW-1:0] wreg,
  input logic          skip_flush,
  input logic          pc_adv
);
  // R8
  re_pulse_chk: assert property (@(posedge clk) disable iff (rst) mem_re |=> !mem_re);
  // R8
  re_phase_chk: assert property (@(posedge clk) disable iff (rst) mem_re |-> busy && q_phase == 2'd1);
  // R4
  we_phase_chk: assert property (@(posedge clk) disable iff (rst) mem_we |-> busy && q_phase == 2'd3);
  // R4
  we_pulse_chk: assert property (@(posedge clk) disable iff (rst) mem_we |=> !mem_we);
  // R4
  we_addr_chk: assert property (@(posedge clk) disable iff (rst) mem_we |-> $stable(mem_addr));
  // R6
  flush_phase_chk: assert property (@(posedge clk) disable iff (rst) skip_flush |-> busy && q_phase == 2'd3);
  // R7
  flush_nop_chk: assert property (@(posedge clk) disable iff (rst) skip_flush |=> busy && q_phase == 2'd0);
  // R7
  pcadv_chk: assert property (@(posedge clk) disable iff (rst) pc_adv |-> busy && q_phase == 2'd3 && !skip_flush);
  // R5
  wreg_hold_chk: assert property (@(posedge clk) disable iff (rst) !$stable(wreg) |-> busy && q_phase == 2'd3);
  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst) !busy |-> !mem_re && !mem_we && !skip_flush && !pc_adv);
  // R8
  start_phase_chk: assert property (@(posedge clk) disable iff (rst) $rose(busy) |-> q_phase == 2'd0);
endmodule

bind incskip_exec incskip_exec_chk #(.AW(BW + FW), .DW(DW)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .busy       (busy),
  .q_phase    (q_phase),
  .mem_addr   (mem_addr),
  .mem_re     (mem_re),
  .mem_we     (mem_we),
  .wreg       (wreg),
  .skip_flush (skip_flush),
  .pc_adv     (pc_adv)
);

// File: tb/sim_incskip_exec.sv
module sim_incskip_exec;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        instr_valid = 1'b0;
  logic [15:0] instr_word = '0;
  logic [3:0]  bsr = '0;
  logic        next_two_word = 1'b0;
  logic [7:0]  mem_rdata;
  logic        busy;
  logic [1:0]  q_phase;
  logic [11:0] mem_addr;
  logic        mem_re, mem_we, skip_flush, pc_adv;
  logic [7:0]  mem_wdata, wreg;

  logic        pre_we = 1'b0;
  logic [11:0] pre_addr = '0;
  logic [7:0]  pre_data = '0;
  logic [7:0]  mem [4096];

  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  incskip_exec u0 (
    .clk(clk), .rst(rst), .instr_valid(instr_valid), .instr_word(instr_word),
    .bsr(bsr), .next_two_word(next_two_word), .mem_rdata(mem_rdata),
    .busy(busy), .q_phase(q_phase), .mem_addr(mem_addr), .mem_re(mem_re),
    .mem_we(mem_we), .mem_wdata(mem_wdata), .wreg(wreg),
    .skip_flush(skip_flush), .pc_adv(pc_adv)
  );

  always @(posedge clk) begin
    if (pre_we) mem[pre_addr] <= pre_data;
    else if (mem_we) mem[mem_addr] <= mem_wdata;
    if (mem_re) mem_rdata <= mem[mem_addr];
  end

  typedef struct packed {
    logic [15:0] iw;
    logic [3:0]  bs;
    logic        tw;
    logic [7:0]  init;
    logic [11:0] addr;
    logic [7:0]  res;
    logic        skip;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VT [NV] = '{
    '{16'h3E10, 4'h5, 1'b0, 8'h41, 12'h010, 8'h42, 1'b0},
    '{16'h3F90, 4'h3, 1'b0, 8'hFF, 12'h390, 8'h00, 1'b1},
    '{16'h3C85, 4'h7, 1'b1, 8'hFF, 12'hF85, 8'h00, 1'b1},
    '{16'h4A20, 4'h9, 1'b0, 8'h07, 12'h020, 8'h08, 1'b1},
    '{16'h4BC0, 4'hA, 1'b1, 8'hFF, 12'hAC0, 8'h00, 1'b0},
    '{16'h4880, 4'h2, 1'b1, 8'h7F, 12'hF80, 8'h80, 1'b1},
    '{16'h3D7F, 4'h1, 1'b0, 8'h00, 12'h17F, 8'h01, 1'b0},
    '{16'h4A7F, 4'hF, 1'b0, 8'hFF, 12'h07F, 8'h00, 1'b0}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic preload(input logic [11:0] a, input logic [7:0] d);
    @(negedge clk); pre_we = 1'b1; pre_addr = a; pre_data = d;
    @(negedge clk); pre_we = 1'b0;
  endtask

  task automatic run(input logic [15:0] iw, input logic [3:0] b, input logic tw,
                     output int cyc, output int nre, output int nwe,
                     output int nfl, output int npc, output logic [11:0] ra);
    cyc = 0; nre = 0; nwe = 0; nfl = 0; npc = 0; ra = '0;
    @(negedge clk);
    instr_word = iw; bsr = b; next_two_word = tw; instr_valid = 1'b1;
    @(negedge clk);
    instr_valid = 1'b0;
    while (busy && cyc < 40) begin
      if (mem_re) begin nre++; ra = mem_addr; end
      if (mem_we) nwe++;
      if (skip_flush) nfl++;
      if (pc_adv) npc++;
      cyc++;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=0 exp=1");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int cyc, nre, nwe, nfl, npc;
    logic [11:0] ra;
    logic [7:0] w_before;
    int exp_cyc;

    repeat (3) @(negedge clk);
    // R10 reset state
    chk(busy == 1'b0 && mem_we == 1'b0 && mem_re == 1'b0, "R10 busy/strobes", {busy, mem_we, mem_re}, 0);
    chk(wreg == 8'h00 && skip_flush == 1'b0 && pc_adv == 1'b0, "R10 wreg/flush", {wreg, skip_flush, pc_adv}, 0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      preload(VT[i].addr, VT[i].init);
      w_before = wreg;
      run(VT[i].iw, VT[i].bs, VT[i].tw, cyc, nre, nwe, nfl, npc, ra);
      exp_cyc = VT[i].skip ? (VT[i].tw ? 12 : 8) : 4;
      // R2 R3 address formation, R8 single read
      chk(nre == 1 && ra == VT[i].addr, $sformatf("R2/R3 addr v%0d", i), ra, VT[i].addr);
      if (VT[i].iw[9]) begin
        // R4 write back to file, W unchanged
        chk(mem[VT[i].addr] == VT[i].res && nwe == 1, $sformatf("R4 file v%0d", i), mem[VT[i].addr], VT[i].res);
        chk(wreg == w_before, $sformatf("R4 wreg kept v%0d", i), wreg, w_before);
      end else begin
        // R5 result to W, memory untouched
        chk(wreg == VT[i].res, $sformatf("R5 wreg v%0d", i), wreg, VT[i].res);
        chk(mem[VT[i].addr] == VT[i].init && nwe == 0, $sformatf("R5 no write v%0d", i), mem[VT[i].addr], VT[i].init);
      end
      // R6 skip decision
      chk(nfl == (VT[i].skip ? 1 : 0), $sformatf("R6 flush v%0d", i), nfl, VT[i].skip);
      // R7 duration and pc advance
      chk(cyc == exp_cyc, $sformatf("R7 busy v%0d", i), cyc, exp_cyc);
      chk(npc == (VT[i].skip ? (VT[i].tw ? 2 : 1) : 0), $sformatf("R7 pc_adv v%0d", i), npc, VT[i].skip);
    end

    // R1 unknown opcode ignored
    @(negedge clk);
    instr_word = 16'h3A10; instr_valid = 1'b1;
    @(negedge clk);
    instr_valid = 1'b0;
    chk(busy == 1'b0 && mem_re == 1'b0, "R1 unknown opcode", busy, 0);
    @(negedge clk);
    chk(busy == 1'b0 && mem_re == 1'b0, "R1 unknown opcode later", mem_re, 0);

    // R9 request while busy ignored
    preload(12'h030, 8'h05);
    preload(12'h031, 8'h09);
    @(negedge clk);
    instr_word = 16'h3E30; bsr = 4'h0; next_two_word = 1'b0; instr_valid = 1'b1;
    @(negedge clk);
    instr_word = 16'h3E31;
    @(negedge clk);
    @(negedge clk);
    instr_valid = 1'b0;
    cyc = 2;
    while (busy && cyc < 40) begin cyc++; @(negedge clk); end
    chk(cyc == 4, "R9 duration", cyc, 4);
    chk(mem[12'h030] == 8'h06, "R9 first executed", mem[12'h030], 8'h06);
    chk(mem[12'h031] == 8'h09, "R9 second ignored", mem[12'h031], 8'h09);
    @(negedge clk);
    chk(busy == 1'b0, "R9 no late start", busy, 0);

    // R8 phase sequence across one instruction
    preload(12'h040, 8'h10);
    @(negedge clk);
    instr_word = 16'h3E40; instr_valid = 1'b1;
    @(negedge clk);
    instr_valid = 1'b0;
    for (int p = 0; p < 4; p++) begin
      chk(q_phase == 2'(p) && busy, "R8 phase", q_phase, p);
      chk(mem_re == (p == 1), "R8 read phase", mem_re, (p == 1));
      @(negedge clk);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule